// File: doc/BRIEF.md
# Processor Stream Access Port

This unit sits between a sequential processor and a set of compute pages on a reconfigurable array. It moves single data words over numbered, persistent streams. The processor names a stream by a small identifier and sends or receives one word per access. A connection that is resident and owned by the calling process completes in the same cycle the request is presented. Each stream slot holds a short FIFO, so the processor and the page do not have to meet in the same cycle.

A separate kernel port configures the slots and controls the pages. It can bind a slot, which sets its residency, direction and owning process and empties its FIFO. It can start or stop the page behind a slot, and it can read a status word for any slot. User requests carry a process identifier and are refused unless the slot is resident, points the right way and belongs to that process. A stopped page sees its stream handshakes held not-ready, so no tokens cross its boundary while it is stopped.

Top module: `strm_access_port`

## Requirements
- R1: After reset every slot is non-resident, stopped and empty: the status word reads 0, every `pgOutValid` and `pgInReady` bit is 0, and any user access reports `cpuError`.
- R2: A write (`cpuWrite`=1) to a resident slot with direction bit 1 (processor to page), owned by `cpuPid`, with fewer than DEPTH words stored, asserts `cpuDone` in the same cycle and appends `cpuWrData` to that slot's FIFO.
- R3: A read (`cpuWrite`=0) to a resident slot with direction bit 0 (page to processor), owned by `cpuPid`, and holding at least one word, asserts `cpuDone`, presents the oldest stored word on `cpuRdData` in the same cycle, and removes it.
- R4: An access to a non-resident slot, a slot of the other direction, or a slot owned by another process asserts `cpuError` only (no `cpuDone`, no `cpuStall`) and leaves the slot's FIFO unchanged.
- R5: A permitted write to a full FIFO, or a permitted read from an empty FIFO, asserts `cpuStall` without `cpuDone` and leaves the FIFO unchanged, until the access can complete.
- R6: While a slot's page is stopped, its `pgOutValid` and `pgInReady` are held at 0 whatever the FIFO holds and whatever the page drives; after a start they follow the FIFO state (valid when not empty, ready when not full).
- R7: Kernel op codes on `kOp`: 2'b00 status only, 2'b01 start, 2'b10 stop, 2'b11 bind. A bind writes residency from `kResident`, direction from `kDir`, owner from `kPid`, stops the page and empties the FIFO. `kStatus` for slot `kSlot` is {running[5], resident[4], direction[3], stored word count[2:0]}.
- R8: Words leave a FIFO in the order they entered, in both directions, and a push and a pop on the same slot in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor stream access request |
| cpuWrite | input | 1 | 1 = send word on stream, 0 = receive word |
| cpuStreamId | input | 3 | Stream slot identifier |
| cpuPid | input | 4 | Process identifier of the running process |
| cpuWrData | input | 32 | Word to send |
| cpuRdData | output | 32 | Oldest word of the addressed slot |
| cpuDone | output | 1 | Access completes this cycle |
| cpuStall | output | 1 | Access permitted but FIFO full/empty |
| cpuError | output | 1 | Access refused (residency, direction, owner) |
| kValid | input | 1 | Kernel operation strobe |
| kOp | input | 2 | Kernel operation code |
| kSlot | input | 3 | Slot addressed by kernel op and status |
| kPid | input | 4 | Owner written by bind |
| kDir | input | 1 | Direction written by bind (1 = processor to page) |
| kResident | input | 1 | Residency written by bind |
| kStatus | output | 6 | Status word of slot `kSlot` |
| pgOutValid | output | 8 | Per slot: word offered to page |
| pgOutReady | input | 8 | Per slot: page accepts word |
| pgOutData | output | 256 | Per slot word to page, slot i at bits [32i+31:32i] |
| pgInValid | input | 8 | Per slot: page offers word |
| pgInReady | output | 8 | Per slot: port accepts word from page |
| pgInData | input | 256 | Per slot word from page, slot i at bits [32i+31:32i] |

## Verification
On every cycle the assertions check that a refused access never also completes or stalls, that a refused access leaves the addressed FIFO count where it was, that a completed write grows and a completed read shrinks that count by one, that a stall only happens on a full or empty FIFO, and that no stopped page ever sees a valid or ready handshake. Word values and their ordering, the status encoding, the effect of bind on stored words and the overlap of a page push with a processor pop are visible only through the bench's scenarios, which follow words from one side of the port to the other.

// File: rtl/sap_pkg.sv
package sap_pkg;

  typedef enum logic [1:0] {
    KOP_STATUS = 2'b00,
    KOP_START  = 2'b01,
    KOP_STOP   = 2'b10,
    KOP_BIND   = 2'b11
  } kop_e;

  // Strobes from control to datapath; slot selects travel beside them.
  typedef struct packed {
    logic cpuPush;
    logic cpuPop;
    logic slotClear;
  } strobe_t;

endpackage

// File: rtl/sap_fifo.sv
module sap_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [FILL_W-1:0] fill,
  output logic              full,
  output logic              empty
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  wrPtr;
  logic              doPush;
  logic              doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (fill == FILL_W'(DEPTH));
  assign empty  = (fill == '0);
  assign doPop  = pop && !empty;
  assign doPush = push && (!full || doPop);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !clear) mem[wrPtr] <= pushData;
  end

endmodule

// File: rtl/sap_ctrl.sv
module sap_ctrl
  import sap_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int PID_W     = 4,
  localparam int IDW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuValid,
  input  logic                 cpuWrite,
  input  logic [IDW-1:0]       cpuStreamId,
  input  logic [PID_W-1:0]     cpuPid,
  input  logic                 kValid,
  input  logic [1:0]           kOp,
  input  logic [IDW-1:0]       kSlot,
  input  logic [PID_W-1:0]     kPid,
  input  logic                 kDir,
  input  logic                 kResident,
  input  logic [NUM_SLOTS-1:0] fullVec,
  input  logic [NUM_SLOTS-1:0] emptyVec,
  output strobe_t              strobes,
  output logic [IDW-1:0]       cpuSel,
  output logic [IDW-1:0]       kSel,
  output logic [NUM_SLOTS-1:0] residentVec,
  output logic [NUM_SLOTS-1:0] dirVec,
  output logic [NUM_SLOTS-1:0] runningVec,
  output logic                 cpuDone,
  output logic                 cpuStall,
  output logic                 cpuError
);

  logic [PID_W-1:0] owner [NUM_SLOTS];
  kop_e             op;
  logic             permitted;
  logic             blocked;

  assign op     = kop_e'(kOp);
  assign cpuSel = cpuStreamId;
  assign kSel   = kSlot;

  // Access check: residency, direction and ownership of the named slot.
  always_comb begin
    permitted = residentVec[cpuStreamId]
             && (dirVec[cpuStreamId] == cpuWrite)
             && (owner[cpuStreamId] == cpuPid);
    blocked   = cpuWrite ? fullVec[cpuStreamId] : emptyVec[cpuStreamId];
    cpuError  = cpuValid && !permitted;
    cpuStall  = cpuValid && permitted && blocked;
    cpuDone   = cpuValid && permitted && !blocked;
    strobes.cpuPush   = cpuDone && cpuWrite;
    strobes.cpuPop    = cpuDone && !cpuWrite;
    strobes.slotClear = kValid && (op == KOP_BIND);
  end

  // Slot table, written only by the kernel port.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      residentVec <= '0;
      dirVec      <= '0;
      runningVec  <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) owner[i] <= '0;
    end else if (kValid) begin
      case (op)
        KOP_START: runningVec[kSlot] <= 1'b1;
        KOP_STOP:  runningVec[kSlot] <= 1'b0;
        KOP_BIND: begin
          residentVec[kSlot] <= kResident;
          dirVec[kSlot]      <= kDir;
          owner[kSlot]       <= kPid;
          runningVec[kSlot]  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sap_datapath.sv
module sap_datapath
  import sap_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 4,
  localparam int IDW    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strobes,
  input  logic [IDW-1:0]                cpuSel,
  input  logic [IDW-1:0]                kSel,
  input  logic [NUM_SLOTS-1:0]          residentVec,
  input  logic [NUM_SLOTS-1:0]          dirVec,
  input  logic [NUM_SLOTS-1:0]          runningVec,
  input  logic [DATA_W-1:0]             cpuWrData,
  output logic [DATA_W-1:0]             cpuRdData,
  output logic [NUM_SLOTS-1:0]          pgOutValid,
  input  logic [NUM_SLOTS-1:0]          pgOutReady,
  output logic [NUM_SLOTS*DATA_W-1:0]   pgOutData,
  input  logic [NUM_SLOTS-1:0]          pgInValid,
  output logic [NUM_SLOTS-1:0]          pgInReady,
  input  logic [NUM_SLOTS*DATA_W-1:0]   pgInData,
  output logic [NUM_SLOTS-1:0]          fullVec,
  output logic [NUM_SLOTS-1:0]          emptyVec,
  output logic [NUM_SLOTS*FILL_W-1:0]   fillFlat
);

  logic [DATA_W-1:0] headArr [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic              live;
    logic              push;
    logic              pop;
    logic              clr;
    logic [DATA_W-1:0] pushData;

    // A page handshake only exists on a resident, running slot.
    assign live = residentVec[i] && runningVec[i];
    assign pgOutValid[i] = live && dirVec[i] && !emptyVec[i];
    assign pgInReady[i]  = live && !dirVec[i] && !fullVec[i];
    assign pgOutData[i*DATA_W +: DATA_W] = headArr[i];

    assign clr = strobes.slotClear && (kSel == IDW'(i));
    always_comb begin
      if (dirVec[i]) begin
        push     = strobes.cpuPush && (cpuSel == IDW'(i));
        pushData = cpuWrData;
        pop      = pgOutValid[i] && pgOutReady[i];
      end else begin
        push     = pgInValid[i] && pgInReady[i];
        pushData = pgInData[i*DATA_W +: DATA_W];
        pop      = strobes.cpuPop && (cpuSel == IDW'(i));
      end
    end

    sap_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .clear    (clr),
      .push     (push),
      .pushData (pushData),
      .pop      (pop),
      .head     (headArr[i]),
      .fill     (fillFlat[i*FILL_W +: FILL_W]),
      .full     (fullVec[i]),
      .empty    (emptyVec[i])
    );
  end

  assign cpuRdData = headArr[cpuSel];

endmodule

// File: rtl/strm_access_port.sv
module strm_access_port
  import sap_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 4,
  parameter int PID_W     = 4,
  localparam int IDW    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int FILL_W = $clog2(DEPTH + 1),
  localparam int STAT_W = FILL_W + 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cpuValid,
  input  logic                        cpuWrite,
  input  logic [IDW-1:0]              cpuStreamId,
  input  logic [PID_W-1:0]            cpuPid,
  input  logic [DATA_W-1:0]           cpuWrData,
  output logic [DATA_W-1:0]           cpuRdData,
  output logic                        cpuDone,
  output logic                        cpuStall,
  output logic                        cpuError,
  input  logic                        kValid,
  input  logic [1:0]                  kOp,
  input  logic [IDW-1:0]              kSlot,
  input  logic [PID_W-1:0]            kPid,
  input  logic                        kDir,
  input  logic                        kResident,
  output logic [STAT_W-1:0]           kStatus,
  output logic [NUM_SLOTS-1:0]        pgOutValid,
  input  logic [NUM_SLOTS-1:0]        pgOutReady,
  output logic [NUM_SLOTS*DATA_W-1:0] pgOutData,
  input  logic [NUM_SLOTS-1:0]        pgInValid,
  output logic [NUM_SLOTS-1:0]        pgInReady,
  input  logic [NUM_SLOTS*DATA_W-1:0] pgInData
);

  strobe_t                    strobes;
  logic [IDW-1:0]             cpuSel;
  logic [IDW-1:0]             kSel;
  logic [NUM_SLOTS-1:0]       residentVec;
  logic [NUM_SLOTS-1:0]       dirVec;
  logic [NUM_SLOTS-1:0]       runningVec;
  logic [NUM_SLOTS-1:0]       fullVec;
  logic [NUM_SLOTS-1:0]       emptyVec;
  logic [NUM_SLOTS*FILL_W-1:0] fillFlat;

  sap_ctrl #(.NUM_SLOTS(NUM_SLOTS), .PID_W(PID_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuValid    (cpuValid),
    .cpuWrite    (cpuWrite),
    .cpuStreamId (cpuStreamId),
    .cpuPid      (cpuPid),
    .kValid      (kValid),
    .kOp         (kOp),
    .kSlot       (kSlot),
    .kPid        (kPid),
    .kDir        (kDir),
    .kResident   (kResident),
    .fullVec     (fullVec),
    .emptyVec    (emptyVec),
    .strobes     (strobes),
    .cpuSel      (cpuSel),
    .kSel        (kSel),
    .residentVec (residentVec),
    .dirVec      (dirVec),
    .runningVec  (runningVec),
    .cpuDone     (cpuDone),
    .cpuStall    (cpuStall),
    .cpuError    (cpuError)
  );

  sap_datapath #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cpuSel      (cpuSel),
    .kSel        (kSel),
    .residentVec (residentVec),
    .dirVec      (dirVec),
    .runningVec  (runningVec),
    .cpuWrData   (cpuWrData),
    .cpuRdData   (cpuRdData),
    .pgOutValid  (pgOutValid),
    .pgOutReady  (pgOutReady),
    .pgOutData   (pgOutData),
    .pgInValid   (pgInValid),
    .pgInReady   (pgInReady),
    .pgInData    (pgInData),
    .fullVec     (fullVec),
    .emptyVec    (emptyVec),
    .fillFlat    (fillFlat)
  );

  assign kStatus = {runningVec[kSlot], residentVec[kSlot], dirVec[kSlot],
                    fillFlat[kSlot*FILL_W +: FILL_W]};

endmodule

// File: rtl/sap_checker.sv
module sap_checker #(
  parameter int NUM_SLOTS = 8,
  parameter int DEPTH     = 4,
  localparam int IDW    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        cpuValid,
  input logic                        cpuWrite,
  input logic [IDW-1:0]              cpuStreamId,
  input logic                        cpuDone,
  input logic                        cpuStall,
  input logic                        cpuError,
  input logic                        kValid,
  input logic [1:0]                  kOp,
  input logic [IDW-1:0]              kSlot,
  input logic [NUM_SLOTS-1:0]        pgOutValid,
  input logic [NUM_SLOTS-1:0]        pgOutReady,
  input logic [NUM_SLOTS-1:0]        pgInValid,
  input logic [NUM_SLOTS-1:0]        pgInReady,
  input logic [NUM_SLOTS-1:0]        runningVec,
  input logic [NUM_SLOTS*FILL_W-1:0] fillFlat
);

  logic [IDW-1:0]    lastId;
  logic [FILL_W-1:0] selFill;
  logic [FILL_W-1:0] fillAtLast;
  logic              pageMove;
  logic              bindHere;

  always_ff @(posedge clk) begin
    if (!rstN) lastId <= '0;
    else       lastId <= cpuStreamId;
  end

  assign selFill    = fillFlat[int'(cpuStreamId)*FILL_W +: FILL_W];
  assign fillAtLast = fillFlat[int'(lastId)*FILL_W +: FILL_W];
  assign pageMove   = (pgOutValid[cpuStreamId] && pgOutReady[cpuStreamId])
                   || (pgInValid[cpuStreamId] && pgInReady[cpuStreamId]);
  assign bindHere   = kValid && (kOp == 2'b11) && (kSlot == cpuStreamId);

  assert_error_alone_R4: assert property (@(posedge clk) disable iff (!rstN)
    cpuError |-> (!cpuDone && !cpuStall));

  assert_error_keeps_fifo_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuError && !pageMove && !bindHere) |=> (fillAtLast == $past(selFill)));

  assert_write_grows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDone && cpuWrite && !pageMove && !bindHere)
      |=> (fillAtLast == FILL_W'($past(selFill) + 1'b1)));

  assert_read_shrinks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDone && !cpuWrite && !pageMove && !bindHere)
      |=> (fillAtLast == FILL_W'($past(selFill) - 1'b1)));

  assert_stall_only_at_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    cpuStall |-> (cpuWrite ? (selFill == FILL_W'(DEPTH)) : (selFill == '0)));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
    assert_stopped_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
      !runningVec[i] |-> (!pgOutValid[i] && !pgInReady[i]));
  end

endmodule

bind strm_access_port sap_checker #(.NUM_SLOTS(NUM_SLOTS), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cpuValid    (cpuValid),
  .cpuWrite    (cpuWrite),
  .cpuStreamId (cpuStreamId),
  .cpuDone     (cpuDone),
  .cpuStall    (cpuStall),
  .cpuError    (cpuError),
  .kValid      (kValid),
  .kOp         (kOp),
  .kSlot       (kSlot),
  .pgOutValid  (pgOutValid),
  .pgOutReady  (pgOutReady),
  .pgInValid   (pgInValid),
  .pgInReady   (pgInReady),
  .runningVec  (runningVec),
  .fillFlat    (fillFlat)
);

// File: tb/strm_access_port_test.sv
module strm_access_port_test;

  localparam int N  = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [2:0]    cpuStreamId = '0;
  logic [3:0]    cpuPid = '0;
  logic [DW-1:0] cpuWrData = '0;
  logic [DW-1:0] cpuRdData;
  logic          cpuDone, cpuStall, cpuError;
  logic          kValid = 1'b0;
  logic [1:0]    kOp = '0;
  logic [2:0]    kSlot = '0;
  logic [3:0]    kPid = '0;
  logic          kDir = 1'b0, kResident = 1'b0;
  logic [5:0]    kStatus;
  logic [N-1:0]  pgOutValid, pgInReady;
  logic [N-1:0]  pgOutReady = '0, pgInValid = '0;
  logic [N*DW-1:0] pgOutData;
  logic [N*DW-1:0] pgInData = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  strm_access_port uut (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuStreamId(cpuStreamId), .cpuPid(cpuPid), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .cpuDone(cpuDone), .cpuStall(cpuStall),
    .cpuError(cpuError), .kValid(kValid), .kOp(kOp), .kSlot(kSlot),
    .kPid(kPid), .kDir(kDir), .kResident(kResident), .kStatus(kStatus),
    .pgOutValid(pgOutValid), .pgOutReady(pgOutReady), .pgOutData(pgOutData),
    .pgInValid(pgInValid), .pgInReady(pgInReady), .pgInData(pgInData)
  );

  typedef struct packed {
    logic          wr;
    logic [2:0]    id;
    logic [3:0]    pid;
    logic [DW-1:0] data;
    logic          expDone;
    logic          expStall;
    logic          expErr;
    logic          chkRd;
    logic [DW-1:0] expRd;
  } vec_t;

  localparam logic [DW-1:0] A0 = 32'hA0A0_0001;
  localparam logic [DW-1:0] A1 = 32'hA0A0_0002;

  // Slot 0: out, pid 3. Slot 1: in, pid 3, preloaded A0,A1. Slot 2: out, pid 5. Slot 3: unbound.
  localparam vec_t VECS [0:12] = '{
    '{1'b1, 3'd0, 4'd3, 32'h11, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b1, 3'd0, 4'd3, 32'h22, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b1, 3'd0, 4'd3, 32'h33, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b1, 3'd0, 4'd3, 32'h44, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b1, 3'd0, 4'd3, 32'h55, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},
    '{1'b0, 3'd1, 4'd3, 32'h0,  1'b1, 1'b0, 1'b0, 1'b1, A0},
    '{1'b0, 3'd1, 4'd3, 32'h0,  1'b1, 1'b0, 1'b0, 1'b1, A1},
    '{1'b0, 3'd1, 4'd3, 32'h0,  1'b0, 1'b1, 1'b0, 1'b0, 32'h0},
    '{1'b1, 3'd1, 4'd3, 32'h66, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
    '{1'b0, 3'd0, 4'd3, 32'h0,  1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
    '{1'b1, 3'd2, 4'd3, 32'h67, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
    '{1'b1, 3'd3, 4'd3, 32'h68, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
    '{1'b1, 3'd2, 4'd5, 32'h77, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0}
  };

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic kernel(input logic [1:0] op, input logic [2:0] slot, input logic [3:0] pid,
                        input logic dir, input logic res);
    @(negedge clk);
    kValid = 1'b1; kOp = op; kSlot = slot; kPid = pid; kDir = dir; kResident = res;
    @(negedge clk);
    kValid = 1'b0;
  endtask

  task automatic checkStatus(input logic [2:0] slot, input logic [5:0] exp, input string req);
    @(negedge clk);
    kSlot = slot;
    #1;
    check(kStatus == exp, req, 32'(kStatus), 32'(exp));
  endtask

  task automatic access(input vec_t v);
    string req;
    req = v.expErr ? "R4" : v.expStall ? "R5" : v.wr ? "R2" : "R3";
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = v.wr; cpuStreamId = v.id; cpuPid = v.pid; cpuWrData = v.data;
    #1;
    check({cpuDone, cpuStall, cpuError} == {v.expDone, v.expStall, v.expErr}, req,
          32'({cpuDone, cpuStall, cpuError}), 32'({v.expDone, v.expStall, v.expErr}));
    if (v.chkRd) check(cpuRdData == v.expRd, "R3 data", cpuRdData, v.expRd);
    @(negedge clk);
    cpuValid = 1'b0;
  endtask

  function automatic vec_t mk(input logic wr, input logic [2:0] id, input logic [3:0] pid,
                              input logic [DW-1:0] d, input logic dn, input logic st,
                              input logic er, input logic cr, input logic [DW-1:0] rd);
    vec_t v;
    v = '{wr, id, pid, d, dn, st, er, cr, rd};
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pgInValid = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1: reset state
    checkStatus(3'd0, 6'b000000, "R1 status slot0");
    checkStatus(3'd7, 6'b000000, "R1 status slot7");
    #1;
    check(pgOutValid == '0, "R1 pgOutValid", 32'(pgOutValid), 32'h0);
    check(pgInReady == '0, "R1 pgInReady", 32'(pgInReady), 32'h0);
    pgInValid = '0;
    access(mk(1'b1, 3'd0, 4'd0, 32'h1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0)); // R1 unbound refused

    // R7: bind slots
    kernel(2'b11, 3'd0, 4'd3, 1'b1, 1'b1);
    kernel(2'b11, 3'd1, 4'd3, 1'b0, 1'b1);
    kernel(2'b11, 3'd2, 4'd5, 1'b1, 1'b1);
    checkStatus(3'd1, 6'b010000, "R7 bind inbound");

    // R6: start slot 1 and preload two words from the page
    kernel(2'b01, 3'd1, 4'd0, 1'b0, 1'b0);
    #1;
    check(pgInReady[1] == 1'b1, "R6 started ready", 32'(pgInReady[1]), 32'h1);
    @(negedge clk);
    pgInValid[1] = 1'b1; pgInData[1*DW +: DW] = A0;
    @(negedge clk);
    pgInData[1*DW +: DW] = A1;
    @(negedge clk);
    pgInValid[1] = 1'b0;
    kernel(2'b10, 3'd1, 4'd0, 1'b0, 1'b0);
    pgInValid[1] = 1'b1; pgInData[1*DW +: DW] = 32'hDEAD;
    #1;
    check(pgInReady[1] == 1'b0, "R6 stopped not ready", 32'(pgInReady[1]), 32'h0);
    checkStatus(3'd1, 6'b010010, "R6 stopped takes nothing");
    pgInValid[1] = 1'b0;

    // Vector table
    foreach (VECS[i]) access(VECS[i]);

    checkStatus(3'd0, 6'b011100, "R7 status full out slot");
    checkStatus(3'd2, 6'b011001, "R7 status slot2");
    checkStatus(3'd1, 6'b010000, "R4 errors left slot1 empty");
    checkStatus(3'd3, 6'b000000, "R4 unbound slot unchanged");

    // R8: drain slot 0 in order
    kernel(2'b01, 3'd0, 4'd0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      pgOutReady[0] = 1'b1;
      #1;
      check(pgOutValid[0] && pgOutData[0 +: DW] == 32'(8'h11 * (k + 1)), "R8 out order",
            pgOutData[0 +: DW], 32'(8'h11 * (k + 1)));
    end
    @(negedge clk);
    #1;
    check(pgOutValid[0] == 1'b0, "R8 drained", 32'(pgOutValid[0]), 32'h0);
    pgOutReady[0] = 1'b0;

    // R6: stopped outbound page sees no valid
    kernel(2'b10, 3'd0, 4'd0, 1'b0, 1'b0);
    access(mk(1'b1, 3'd0, 4'd3, 32'h12, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0));
    pgOutReady[0] = 1'b1;
    #1;
    check(pgOutValid[0] == 1'b0, "R6 stopped not valid", 32'(pgOutValid[0]), 32'h0);
    checkStatus(3'd0, 6'b011001, "R6 word held while stopped");
    pgOutReady[0] = 1'b0;

    // R8: simultaneous page push and processor pop on slot 1
    kernel(2'b01, 3'd1, 4'd0, 1'b0, 1'b0);
    @(negedge clk);
    pgInValid[1] = 1'b1; pgInData[1*DW +: DW] = 32'hB000_0000;
    @(negedge clk);
    pgInData[1*DW +: DW] = 32'hB000_0001;
    cpuValid = 1'b1; cpuWrite = 1'b0; cpuStreamId = 3'd1; cpuPid = 4'd3;
    #1;
    check(cpuDone && cpuRdData == 32'hB000_0000, "R8 overlap read", cpuRdData, 32'hB000_0000);
    @(negedge clk);
    pgInValid[1] = 1'b0; cpuValid = 1'b0;
    checkStatus(3'd1, 6'b110001, "R8 overlap count");
    access(mk(1'b0, 3'd1, 4'd3, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'hB000_0001));

    // R7: rebind empties, unbind refuses
    kernel(2'b11, 3'd0, 4'd3, 1'b1, 1'b1);
    checkStatus(3'd0, 6'b011000, "R7 rebind clears");
    kernel(2'b11, 3'd2, 4'd5, 1'b1, 1'b0);
    checkStatus(3'd2, 6'b001000, "R7 unbind status");
    access(mk(1'b1, 3'd2, 4'd5, 32'h88, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule